// File: doc/BRIEF.md
# Burst-of-four separate-port synchronous SRAM model

A cycle-accurate, synthesizable model of a static memory with independent read and write ports, where every access moves a fixed group of four data words. The model runs on a clock at twice the command rate. Each tick of `clk` stands for one rising edge of either the main clock or its complement, and `k_phase` is high on the ticks that are main-clock edges. Commands and the address are taken only on those ticks, so a command slot lasts two ticks. Write data, per-lane write strobes and read data move one word per tick.

The write address is registered with its command. The four data words follow, starting one full command slot later. A read returns its four words starting two and a half slots after the command, and `rvalid` marks each word. With `loop_on` low the read latency drops to one slot. Reads are coherent with writes that have been accepted but not yet completed. A command of the same kind on the slot right after an accepted one is dropped and flagged.

Top module: `qb4_sram`

## Requirements
- R1: With `loop_on` high, a read accepted at K tick T drives its four words on ticks T+5, T+6, T+7 and T+8, one word per tick, with the first word on a tick where `k_phase` is low.
- R2: With `loop_on` low, the four words of a read accepted at tick T appear on ticks T+2 to T+5, with the first word on a tick where `k_phase` is high.
- R3: For a write accepted at tick T, the data words sampled on ticks T+2, T+3, T+4 and T+5 are stored in that order into the four burst locations.
- R4: `wbe_n` has one active-low bit per lane. Bit i covers data bits [i*LANE_W +: LANE_W]. A lane whose bit is high on a word's tick keeps its stored byte.
- R5: `rvalid` is high on exactly the ticks that carry read words. On every other tick `rdata` is zero.
- R6: A read returns the bytes of every write accepted at or before its own command tick, including a write still receiving data.
- R7: The address and data inputs have no effect when neither `rd_n` nor `wr_n` is low on a K tick.
- R8: A read on the K tick right after an accepted read is dropped, and so is a write right after an accepted write. `proto_err` is high for the one tick following that K edge.
- R9: A read and a write given on the same K tick are both carried out.
- R10: The burst covers word addresses base, base+1, base+2 and base+3, where base is the command address with bits [1:0] cleared.
- R11: After reset `rvalid`, `rdata` and `proto_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one rising edge per main or complement clock edge |
| rst_n | input | 1 | Active-low synchronous reset |
| k_phase | input | 1 | High on ticks that are main-clock rising edges |
| loop_on | input | 1 | High: 2.5-slot read latency; low: 1-slot latency |
| rd_n | input | 1 | Active-low read command, sampled on K ticks |
| wr_n | input | 1 | Active-low write command, sampled on K ticks |
| addr | input | ADDR_W | Word address, sampled with a command |
| wdata | input | DATA_W | Write data word, one per tick |
| wbe_n | input | LANES | Active-low per-lane write strobes, one set per tick |
| rdata | output | DATA_W | Read data word, one per tick |
| rvalid | output | 1 | High on ticks carrying a read word |
| proto_err | output | 1 | One-tick pulse for a dropped back-to-back command |

## Verification
A fault in the read sequencer shows at the ports within a few ticks. A burst would start on the wrong phase, run shorter or longer than four words, or put a nonzero value on `rdata` while `rvalid` is low. A fault in the write path or in the same-tick forwarding stays hidden in the array until a later read of that location. A fault in the pending-command state shows as a missing or extra `proto_err` pulse two ticks after the first command, or as words from a dropped command.

// File: rtl/qb4_sram.sv
module qb4_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int BASE_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_phase,
  input  logic              loop_on,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              proto_err
);

  logic              rp_v, ra_v, wp_v, wa_v;
  logic [BASE_W-1:0] rp_base, ra_base, wp_base, wa_base;
  logic [1:0]        ra_idx, wa_idx;
  logic              rd_go, wr_go, r_fire, w_fire;
  logic [ADDR_W-1:0] r_word, w_word;
  logic [DATA_W-1:0] f_next, f_d;
  logic              f_v;
  logic [DATA_W-1:0] dd [3];
  logic [2:0]        dv;

  wire unused_lo = ^addr[1:0];

  assign rd_go  = k_phase && !rd_n && !rp_v;
  assign wr_go  = k_phase && !wr_n && !wp_v;
  assign r_fire = (k_phase && rp_v) || ra_v;
  assign w_fire = (k_phase && wp_v) || wa_v;
  assign r_word = (k_phase && rp_v) ? {rp_base, 2'b00} : {ra_base, ra_idx};
  assign w_word = (k_phase && wp_v) ? {wp_base, 2'b00} : {wa_base, wa_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_v <= 1'b0; ra_v <= 1'b0; ra_idx <= '0;
      rp_base <= '0; ra_base <= '0;
    end else begin
      if (k_phase) begin
        rp_v <= rd_go;
        if (rd_go) rp_base <= addr[ADDR_W-1:2];
      end
      if (k_phase && rp_v) begin
        ra_v <= 1'b1; ra_base <= rp_base; ra_idx <= 2'd1;
      end else if (ra_v) begin
        ra_idx <= ra_idx + 2'd1;
        if (ra_idx == 2'd3) ra_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_v <= 1'b0; wa_v <= 1'b0; wa_idx <= '0;
      wp_base <= '0; wa_base <= '0;
    end else begin
      if (k_phase) begin
        wp_v <= wr_go;
        if (wr_go) wp_base <= addr[ADDR_W-1:2];
      end
      if (k_phase && wp_v) begin
        wa_v <= 1'b1; wa_base <= wp_base; wa_idx <= 2'd1;
      end else if (wa_v) begin
        wa_idx <= wa_idx + 2'd1;
        if (wa_idx == 2'd3) wa_v <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lmem [DEPTH];
    logic              fwd;
    assign fwd = w_fire && !wbe_n[g] && (w_word == r_word);
    assign f_next[g*LANE_W +: LANE_W] = fwd ? wdata[g*LANE_W +: LANE_W] : lmem[r_word];
    always_ff @(posedge clk) begin
      if (w_fire && !wbe_n[g]) lmem[w_word] <= wdata[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_v <= 1'b0; f_d <= '0; dv <= '0;
      dd[0] <= '0; dd[1] <= '0; dd[2] <= '0;
      proto_err <= 1'b0;
    end else begin
      f_v <= r_fire;
      f_d <= r_fire ? f_next : '0;
      dv  <= {dv[1:0], f_v};
      dd[0] <= f_d; dd[1] <= dd[0]; dd[2] <= dd[1];
      proto_err <= k_phase && ((!rd_n && rp_v) || (!wr_n && wp_v));
    end
  end

  assign rdata  = loop_on ? dd[2] : f_d;
  assign rvalid = loop_on ? dv[2] : f_v;

endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              k_phase,
  input logic              loop_on,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              proto_err
);

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  a_r1_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);

  a_r1_kbar_start: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && $rose(rvalid)) |-> !$past(k_phase));

  a_r2_k_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_on && $rose(rvalid)) |-> $past(k_phase));

  a_r1_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && $rose(rvalid)) |-> $past(k_phase && !rd_n, 6));

  a_r2_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_on && $rose(rvalid)) |-> $past(k_phase && !rd_n, 3));

  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(k_phase) && ($past(!rd_n) || $past(!wr_n)));

endmodule

bind qb4_sram qb4_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .loop_on(loop_on),
  .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .rvalid(rvalid),
  .proto_err(proto_err)
);

// File: tb/sim_qb4_sram.sv
module sim_qb4_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0, k_phase = 1'b1, loop_on = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    wbe_n = 2'b11;
  logic [DW-1:0] rdata;
  logic rvalid, proto_err;

  qb4_sram u0 (.clk(clk), .rst_n(rst_n), .k_phase(k_phase), .loop_on(loop_on),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
    .rdata(rdata), .rvalid(rvalid), .proto_err(proto_err));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, tk = 0, ncap = 0, nerr = 0, err_t = -1, zero_bad = 0;
  logic kn = 1'b1;
  logic [DW-1:0] cap_d [64];
  int            cap_t [64];
  logic [DW-1:0] rm [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic rdn, wrn, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [1:0] be);
    k_phase = kn; kn = !kn;
    rd_n = rdn; wr_n = wrn; addr = a; wdata = d; wbe_n = be;
    @(posedge clk); @(negedge clk);
    if (rvalid && ncap < 64) begin cap_d[ncap] = rdata; cap_t[ncap] = tk; ncap++; end
    if (!rvalid && rdata != '0) zero_bad++;
    if (proto_err) begin err_t = tk; nerr++; end
    tk++;
  endtask

  task automatic kc(input logic rdn, wrn, input logic [AW-1:0] a,
                    input logic [DW-1:0] d0, input logic [1:0] b0,
                    input logic [DW-1:0] d1, input logic [1:0] b1);
    tick(rdn, wrn, a, d0, b0);
    tick(1'b1, 1'b1, a, d1, b1);
  endtask

  task automatic idle(input int n);
    repeat (n) kc(1'b1, 1'b1, '0, '0, 2'b11, '0, 2'b11);
  endtask

  task automatic model_wr(input logic [AW-1:0] a, input logic [3:0][DW-1:0] d,
                          input logic [3:0][1:0] be);
    for (int i = 0; i < 4; i++) begin
      int w = int'(a & 6'h3C) + i;
      if (!be[i][0]) rm[w][8:0]  = d[i][8:0];
      if (!be[i][1]) rm[w][17:9] = d[i][17:9];
    end
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input logic [3:0][DW-1:0] d,
                          input logic [3:0][1:0] be);
    kc(1'b1, 1'b0, a, '0, 2'b11, '0, 2'b11);
    kc(1'b1, 1'b1, '0, d[0], be[0], d[1], be[1]);
    kc(1'b1, 1'b1, '0, d[2], be[2], d[3], be[3]);
    model_wr(a, d, be);
  endtask

  task automatic expect_burst(input int start, input logic [AW-1:0] a, input string req);
    int lat = loop_on ? 5 : 2;
    chk(ncap == 4, req, ncap, 4);
    for (int i = 0; i < 4 && i < ncap; i++) begin
      chk(cap_t[i] == start + lat + i, req, cap_t[i], start + lat + i);
      chk(cap_d[i] == rm[int'(a & 6'h3C) + i], req, cap_d[i], rm[int'(a & 6'h3C) + i]);
    end
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string req);
    int start = tk;
    ncap = 0; zero_bad = 0;
    kc(1'b0, 1'b1, a, '0, 2'b11, '0, 2'b11);
    idle(5);
    expect_burst(start, a, req);
    chk(zero_bad == 0, "R5 zero when idle", zero_bad, 0);
  endtask

  task automatic t_reset;
    chk(rvalid == 1'b0, "R11 rvalid", rvalid, 0);
    chk(rdata == '0, "R11 rdata", rdata, 0);
    chk(proto_err == 1'b0, "R11 proto_err", proto_err, 0);
  endtask

  task automatic t_write_read;
    wr_burst(6'd8, {18'h3A5A5, 18'h2C3C3, 18'h1F00F, 18'h00123}, '0);
    wr_burst(6'd16, {18'h11111, 18'h22222, 18'h33333, 18'h04444}, '0);
    wr_burst(6'd24, {18'h15555, 18'h26666, 18'h37777, 18'h08888}, '0);
    wr_burst(6'd20, {18'h00A0A, 18'h00B0B, 18'h00C0C, 18'h00D0D}, '0);
    rd_check(6'd8, "R1/R3 read after write");
    rd_check(6'd16, "R3 second burst");
  endtask

  task automatic t_strobe;
    wr_burst(6'd12, {18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF}, '0);
    wr_burst(6'd12, {18'h12345, 18'h2ABCD, 18'h05A5A, 18'h3C3C3},
             {2'b00, 2'b11, 2'b10, 2'b01});
    rd_check(6'd12, "R4 byte strobes");
  endtask

  task automatic t_align;
    rd_check(6'd10, "R10 base alignment");
    rd_check(6'd27, "R10 base alignment high");
  endtask

  task automatic t_ignore;
    ncap = 0;
    for (int i = 0; i < 4; i++) kc(1'b1, 1'b1, 6'd8, 18'h3DEAD, 2'b00, 18'h3BEEF, 2'b00);
    idle(3);
    chk(ncap == 0, "R7 no output when deselected", ncap, 0);
    rd_check(6'd8, "R7 contents unchanged");
  endtask

  task automatic t_cohere;
    logic [3:0][DW-1:0] d = {18'h1CAFE, 18'h2F00D, 18'h0BEAD, 18'h3ACED};
    int start = tk;
    ncap = 0;
    kc(1'b0, 1'b0, 6'd16, '0, 2'b11, '0, 2'b11);
    kc(1'b1, 1'b1, '0, d[0], 2'b00, d[1], 2'b00);
    kc(1'b1, 1'b1, '0, d[2], 2'b00, d[3], 2'b00);
    idle(3);
    model_wr(6'd16, d, '0);
    expect_burst(start, 6'd16, "R6 coherent same-slot read");
    rd_check(6'd16, "R9 write also done");
  endtask

  task automatic t_b2b;
    logic [3:0][DW-1:0] d = {18'h01234, 18'h05678, 18'h09ABC, 18'h0DEF0};
    int start = tk;
    ncap = 0; nerr = 0;
    kc(1'b0, 1'b1, 6'd8, '0, 2'b11, '0, 2'b11);
    kc(1'b0, 1'b1, 6'd20, '0, 2'b11, '0, 2'b11);
    idle(5);
    expect_burst(start, 6'd8, "R8 second read dropped");
    chk(nerr == 1, "R8 read error count", nerr, 1);
    chk(err_t == start + 2, "R8 read error tick", err_t, start + 2);
    start = tk; nerr = 0;
    kc(1'b1, 1'b0, 6'd20, '0, 2'b11, '0, 2'b11);
    kc(1'b1, 1'b0, 6'd24, d[0], 2'b00, d[1], 2'b00);
    kc(1'b1, 1'b1, '0, d[2], 2'b00, d[3], 2'b00);
    idle(2);
    model_wr(6'd20, d, '0);
    chk(nerr == 1, "R8 write error count", nerr, 1);
    chk(err_t == start + 2, "R8 write error tick", err_t, start + 2);
    rd_check(6'd24, "R8 second write dropped");
    rd_check(6'd20, "R8 first write kept");
  endtask

  task automatic t_loopoff;
    loop_on = 1'b0;
    idle(1);
    rd_check(6'd8, "R2 short latency");
    rd_check(6'd12, "R2 short latency strobed");
    loop_on = 1'b1;
    idle(1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write_read();
    t_strobe();
    t_align();
    t_ignore();
    t_cohere();
    t_b2b();
    t_loopoff();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", tk, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule